// File: doc/BRIEF.md
# Flash Programming Command Receiver

This block is the target side of a byte-serial flash reprogramming session. It takes bytes from an already-decoded UART receiver (a one-cycle strobe with the byte and two line-error flags). It walks a fixed command sequence: session start, erase with a block index, then write with a 32-bit length followed by the data. It drives a flash controller through two request/done handshakes, one for block erase and one for 256-byte page programming. Each time it is ready for the next step, it returns the acknowledge byte 55h through a valid/ready transmit interface.

The block index selects one of three block sizes. The length is checked against the size of the selected block before any data is taken. The data arrives in 256-byte units. Each unit is collected in an internal page buffer, which the flash controller reads through a separate address port while the page-write request is up. Any protocol violation or receive line error moves the block into a sticky error state. It leaves that state only on reset.

Top module: `flash_cmd_target`

## Requirements
- R1: After reset the block sends nothing, requests nothing, reports no error, and waits for a session-start byte.
- R2: The accepted order is: start byte 10h (acknowledged); erase byte 11h followed by one index byte; then write byte 12h followed by four length bytes; then data.
- R3: Index bytes 00h to 0Ah select 128 KiB (131072-byte) blocks, 0Bh to 13h select 64 KiB (65536-byte) blocks, and 14h to 1Bh select 8 KiB (8192-byte) blocks.
- R4: A length of zero, or a length greater than the selected block size, sends no acknowledge and enters the error state. Any other length is acknowledged.
- R5: The four length bytes form one 32-bit value, with the first byte received as bits 31..24.
- R6: After the index byte, erase_req rises with erase_index equal to the index. It stays high until erase_done is seen. The acknowledge follows only after that.
- R7: Data bytes fill the page buffer from address 0 upward. After each 256th byte, write_req rises with write_page numbering the unit in the block, starting at 0 and increasing by one per unit. wbuf_rdata at address k returns the k-th byte of the unit.
- R8: The number of page writes is the length rounded up to a multiple of 256, divided by 256. After the last page is acknowledged, the session ends and a new start byte is accepted.
- R9: The acknowledge is tx_valid high with tx_data 55h. It is held until tx_ready is sampled high. It is sent after the start byte, after the erase completes, after the length is accepted, and after each page write completes.
- R10: rx_overrun or rx_frame_err in any state enters the error state. session_err then stays high until reset.
- R11: Any of the following enters the error state with no acknowledge: a command byte that is not the one expected next, an index above 1Bh, or a byte received while the block is erasing, programming or acknowledging. In the error state all received bytes are ignored.
- R12: write_req stays high with a stable write_page until write_done. erase_req and write_req are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: rx_data holds a received byte |
| rx_data | input | 8 | Received byte |
| rx_overrun | input | 1 | Receiver overrun flag, one cycle |
| rx_frame_err | input | 1 | Receiver framing error flag, one cycle |
| tx_valid | output | 1 | Acknowledge byte is offered |
| tx_data | output | 8 | Byte to transmit (55h) |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| erase_req | output | 1 | Block erase request |
| erase_index | output | 5 | Index of the block to erase |
| erase_done | input | 1 | Erase finished, one cycle |
| write_req | output | 1 | Page programming request |
| write_page | output | 10 | Page number inside the selected block |
| write_done | input | 1 | Page programming finished, one cycle |
| wbuf_raddr | input | 8 | Page buffer read address |
| wbuf_rdata | output | 8 | Page buffer read data |
| session_err | output | 1 | Sticky error state |

## Verification
The assertions assume two things about the environment. First, erase_done and write_done arrive only while the matching request is high. Second, rx_valid never arrives while an acknowledge is waiting, except in deliberate error tests. The bench follows the handshakes strictly: it raises each done strobe only after it has seen the request, and it sends the next byte only after it has completed the acknowledge handshake. Line-error flags and out-of-order bytes are injected only in the directed error cases, and each of those cases ends in a reset.

// File: rtl/fcr_pkg.sv
// Package: shared state encoding and protocol byte values for the
// flash command receiver. Assumes 8-bit protocol bytes.
package fcr_pkg;

    typedef enum logic [3:0] {
        ST_START,   // waiting for session start
        ST_ERCMD,   // waiting for erase command
        ST_INDEX,   // waiting for block index
        ST_ERASE,   // erase in progress
        ST_WRCMD,   // waiting for write command
        ST_LEN,     // collecting length bytes
        ST_DATA,    // collecting page data
        ST_PROG,    // page programming in progress
        ST_ACK,     // offering acknowledge byte
        ST_ERR      // sticky error
    } fcr_state_e;

    localparam logic [7:0] BYTE_START = 8'h10;
    localparam logic [7:0] BYTE_ERASE = 8'h11;
    localparam logic [7:0] BYTE_WRITE = 8'h12;
    localparam logic [7:0] BYTE_ACK   = 8'h55;

endpackage

// File: rtl/fcr_len_check.sv
// Length and index checker. Decodes the block size for a stored index,
// validates a length against it and counts the pages it needs. Also
// range-checks a fresh index byte. Purely combinational.
// Assumes the size regions are contiguous and ascend in index order.
module fcr_len_check #(
    parameter int LEN_W       = 32,
    parameter int PAGE_BYTES  = 256,
    parameter int LARGE_LAST  = 8'h0A,
    parameter int MID_LAST    = 8'h13,
    parameter int SMALL_LAST  = 8'h1B,
    parameter int LARGE_BYTES = 131072,
    parameter int MID_BYTES   = 65536,
    parameter int SMALL_BYTES = 8192,
    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES),
    localparam int PGS_W      = LEN_W - PAGE_SHIFT + 1
) (
    input  logic [7:0]       idx_new,
    input  logic [7:0]       idx_sel,
    input  logic [LEN_W-1:0] len,
    output logic             idx_ok,
    output logic             len_ok,
    output logic [PGS_W-1:0] pages
);

    logic [LEN_W:0] blk_size;

    // Range check for the index byte being received.
    always_comb idx_ok = (idx_new <= 8'(SMALL_LAST));

    // Size of the block chosen by the stored index.
    always_comb begin
        if (idx_sel <= 8'(LARGE_LAST))
            blk_size = (LEN_W+1)'(LARGE_BYTES);
        else if (idx_sel <= 8'(MID_LAST))
            blk_size = (LEN_W+1)'(MID_BYTES);
        else
            blk_size = (LEN_W+1)'(SMALL_BYTES);
    end

    // Accept a nonzero length that fits the block.
    always_comb len_ok = (len != '0) && ({1'b0, len} <= blk_size);

    // Page count: length rounded up to whole pages.
    always_comb pages = PGS_W'(len[LEN_W-1:PAGE_SHIFT])
                      + PGS_W'(|len[PAGE_SHIFT-1:0]);

endmodule

// File: rtl/fcr_page_buf.sv
// Page collection buffer. Writes incoming bytes at ascending addresses
// and flags the byte that completes a page. Read is asynchronous for
// the flash controller. Assumes clr is never raised together with wr_en.
module fcr_page_buf #(
    parameter int PAGE_BYTES = 256,
    parameter int DATA_W     = 8,
    localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              full
);

    logic [DATA_W-1:0] mem [PAGE_BYTES];
    logic [ADDR_W-1:0] wr_ptr;

    // Fill pointer: advances per byte, wraps after a full page.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            wr_ptr <= '0;
        else if (wr_en)
            wr_ptr <= (wr_ptr == ADDR_W'(PAGE_BYTES-1)) ? '0 : wr_ptr + 1'b1;
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_ptr] <= wr_data;
    end

    // Page complete on the last byte of a unit.
    always_comb full = wr_en && (wr_ptr == ADDR_W'(PAGE_BYTES-1));

    // Asynchronous read port.
    always_comb rd_data = mem[rd_addr];

endmodule

// File: rtl/flash_cmd_target.sv
// Flash programming command receiver. Sequences the start, erase and
// write commands from received bytes. Issues the erase and page-write
// requests and returns acknowledge bytes. Assumes rx_valid is a
// one-cycle strobe and done inputs only arrive for a raised request.
module flash_cmd_target #(
    parameter int LEN_W       = 32,
    parameter int PAGE_BYTES  = 256,
    parameter int IDX_W       = 5,
    parameter int LARGE_LAST  = 8'h0A,
    parameter int MID_LAST    = 8'h13,
    parameter int SMALL_LAST  = 8'h1B,
    parameter int LARGE_BYTES = 131072,
    parameter int MID_BYTES   = 65536,
    parameter int SMALL_BYTES = 8192,
    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES),
    localparam int PGS_W      = LEN_W - PAGE_SHIFT + 1,
    localparam int PAGE_CNT_W = $clog2(LARGE_BYTES / PAGE_BYTES) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_data,
    input  logic                  rx_overrun,
    input  logic                  rx_frame_err,
    output logic                  tx_valid,
    output logic [7:0]            tx_data,
    input  logic                  tx_ready,
    output logic                  erase_req,
    output logic [IDX_W-1:0]      erase_index,
    input  logic                  erase_done,
    output logic                  write_req,
    output logic [PAGE_CNT_W-1:0] write_page,
    input  logic                  write_done,
    input  logic [PAGE_SHIFT-1:0] wbuf_raddr,
    output logic [7:0]            wbuf_rdata,
    output logic                  session_err
);
    import fcr_pkg::*;

    fcr_state_e            state, ack_next;
    logic [7:0]            idx_q;
    logic [LEN_W-1:0]      len_q, len_next;
    logic [1:0]            len_cnt;
    logic [PGS_W-1:0]      pages_q, pages_new;
    logic [PAGE_CNT_W-1:0] page_q;
    logic                  idx_ok, len_ok, buf_full, buf_wr, rx_bad, last_page;

    // Next length value with the new byte shifted in at the bottom.
    always_comb len_next = {len_q[LEN_W-9:0], rx_data};

    // Receive-line failure indication.
    always_comb rx_bad = rx_overrun || rx_frame_err;

    // Data bytes go to the page buffer only while collecting.
    always_comb buf_wr = (state == ST_DATA) && rx_valid && !rx_bad;

    // The page being programmed is the final one of the session.
    always_comb last_page = (PGS_W'(page_q) + 1'b1) == pages_q;

    fcr_len_check #(
        .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
        .LARGE_LAST(LARGE_LAST), .MID_LAST(MID_LAST), .SMALL_LAST(SMALL_LAST),
        .LARGE_BYTES(LARGE_BYTES), .MID_BYTES(MID_BYTES), .SMALL_BYTES(SMALL_BYTES)
    ) u_check (
        .idx_new (rx_data),
        .idx_sel (idx_q),
        .len     (len_next),
        .idx_ok  (idx_ok),
        .len_ok  (len_ok),
        .pages   (pages_new)
    );

    fcr_page_buf #(
        .PAGE_BYTES(PAGE_BYTES), .DATA_W(8)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == ST_LEN),
        .wr_en   (buf_wr),
        .wr_data (rx_data),
        .rd_addr (wbuf_raddr),
        .rd_data (wbuf_rdata),
        .full    (buf_full)
    );

    // Session sequencer: command order, handshakes and error capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_START;
            ack_next <= ST_START;
            idx_q    <= '0;
            len_q    <= '0;
            len_cnt  <= '0;
            pages_q  <= '0;
            page_q   <= '0;
        end else if (rx_bad) begin
            state <= ST_ERR;
        end else begin
            case (state)
                ST_START: if (rx_valid) begin
                    if (rx_data == BYTE_START) begin
                        ack_next <= ST_ERCMD;
                        state    <= ST_ACK;
                    end else
                        state <= ST_ERR;
                end
                ST_ERCMD: if (rx_valid)
                    state <= (rx_data == BYTE_ERASE) ? ST_INDEX : ST_ERR;
                ST_INDEX: if (rx_valid) begin
                    idx_q <= rx_data;
                    state <= idx_ok ? ST_ERASE : ST_ERR;
                end
                ST_ERASE: begin
                    if (rx_valid)
                        state <= ST_ERR;
                    else if (erase_done) begin
                        ack_next <= ST_WRCMD;
                        state    <= ST_ACK;
                    end
                end
                ST_WRCMD: if (rx_valid) begin
                    len_cnt <= '0;
                    state   <= (rx_data == BYTE_WRITE) ? ST_LEN : ST_ERR;
                end
                ST_LEN: if (rx_valid) begin
                    len_q   <= len_next;
                    len_cnt <= len_cnt + 1'b1;
                    if (len_cnt == 2'd3) begin
                        if (len_ok) begin
                            pages_q  <= pages_new;
                            page_q   <= '0;
                            ack_next <= ST_DATA;
                            state    <= ST_ACK;
                        end else
                            state <= ST_ERR;
                    end
                end
                ST_DATA: if (buf_full)
                    state <= ST_PROG;
                ST_PROG: begin
                    if (rx_valid)
                        state <= ST_ERR;
                    else if (write_done) begin
                        page_q   <= page_q + 1'b1;
                        ack_next <= last_page ? ST_START : ST_DATA;
                        state    <= ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (rx_valid)
                        state <= ST_ERR;
                    else if (tx_ready)
                        state <= ack_next;
                end
                default: state <= ST_ERR;
            endcase
        end
    end

    // Output decode from the sequencer state.
    always_comb begin
        tx_valid    = (state == ST_ACK);
        tx_data     = BYTE_ACK;
        erase_req   = (state == ST_ERASE);
        erase_index = idx_q[IDX_W-1:0];
        write_req   = (state == ST_PROG);
        write_page  = page_q;
        session_err = (state == ST_ERR);
    end

endmodule

// File: rtl/fcr_checker.sv
// Port-level protocol checker for the flash command receiver, attached
// by bind. Assumes the environment keeps the done-strobe handshakes.
module fcr_checker #(
    parameter int PCW = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rx_overrun,
    input logic           rx_frame_err,
    input logic           tx_valid,
    input logic [7:0]     tx_data,
    input logic           tx_ready,
    input logic           erase_req,
    input logic           erase_done,
    input logic           write_req,
    input logic [PCW-1:0] write_page,
    input logic           write_done,
    input logic           session_err
);

    p_erase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req && !erase_done |=> erase_req);

    p_ack_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_data == 8'h55);

    p_ack_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        session_err |=> session_err);

    p_rx_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun || rx_frame_err |=> session_err);

    p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        session_err |-> !tx_valid && !erase_req && !write_req);

    p_write_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        write_req && !write_done |=> write_req && $stable(write_page));

    p_req_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_req && write_req));

endmodule

bind flash_cmd_target fcr_checker #(.PCW(PAGE_CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_overrun   (rx_overrun),
    .rx_frame_err (rx_frame_err),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .tx_ready     (tx_ready),
    .erase_req    (erase_req),
    .erase_done   (erase_done),
    .write_req    (write_req),
    .write_page   (write_page),
    .write_done   (write_done),
    .session_err  (session_err)
);

// File: tb/flash_cmd_target_tb.sv
// Bench for the flash command receiver: a vector table of index/length
// cases, then directed tests for transfer, handshakes and errors.
module flash_cmd_target_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 0, rst_n = 0;
    logic       rx_valid = 0, rx_overrun = 0, rx_frame_err = 0;
    logic [7:0] rx_data = 0;
    logic       tx_valid, tx_ready = 0;
    logic [7:0] tx_data;
    logic       erase_req, erase_done = 0;
    logic [4:0] erase_index;
    logic       write_req, write_done = 0;
    logic [9:0] write_page;
    logic [7:0] wbuf_raddr = 0, wbuf_rdata;
    logic       session_err;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_target u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_overrun(rx_overrun), .rx_frame_err(rx_frame_err),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .erase_req(erase_req), .erase_index(erase_index), .erase_done(erase_done),
        .write_req(write_req), .write_page(write_page), .write_done(write_done),
        .wbuf_raddr(wbuf_raddr), .wbuf_rdata(wbuf_rdata), .session_err(session_err)
    );

    typedef struct packed {
        logic [7:0]  idx;
        logic [31:0] len;
        logic        acc;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 32'd131072, 1'b1},
        '{8'h00, 32'd131073, 1'b0},
        '{8'h0A, 32'd1,      1'b1},
        '{8'h0B, 32'd65536,  1'b1},
        '{8'h0B, 32'd65537,  1'b0},
        '{8'h13, 32'd0,      1'b0},
        '{8'h14, 32'd8192,   1'b1},
        '{8'h1A, 32'd8193,   1'b0},
        '{8'h1B, 32'd4096,   1'b1},
        '{8'h05, 32'd70000,  1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk) begin rx_valid = 1; rx_data = b; end
        @(negedge clk) rx_valid = 0;
    endtask

    task automatic get_ack(input int delay, output bit got);
        got = 0;
        for (int i = 0; i < 40; i++) begin
            if (tx_valid) begin got = 1; break; end
            @(negedge clk);
        end
        if (got) begin
            repeat (delay) @(negedge clk);
            if (!tx_valid || tx_data != 8'h55) got = 0;
            tx_ready = 1;
            @(negedge clk) tx_ready = 0;
        end
    endtask

    task automatic run_erase(input int hold, input logic [4:0] exp_idx);
        int waited = 0;
        while (!erase_req && waited < 40) begin @(negedge clk); waited++; end
        chk("R6 erase_req raised", erase_req, 1);
        chk("R6 erase_index", erase_index, exp_idx);
        repeat (hold) @(negedge clk);
        chk("R6 erase_req held", erase_req, 1);
        chk("R6 no early ack", tx_valid, 0);
        erase_done = 1;
        @(negedge clk) erase_done = 0;
    endtask

    task automatic open_session(input logic [7:0] idx, input logic [31:0] len,
                                output bit accepted);
        bit got;
        send(8'h10);
        get_ack(0, got);
        chk("R2 start ack", got, 1);
        send(8'h11);
        send(idx);
        run_erase(3, idx[4:0]);
        get_ack(0, got);
        chk("R9 erase ack", got, 1);
        send(8'h12);
        send(len[31:24]); send(len[23:16]); send(len[15:8]); send(len[7:0]);
        get_ack(0, accepted);
    endtask

    function automatic logic [7:0] pat(input int p, input int k);
        return 8'((p * 37 + k * 3 + 5) & 255);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit acc, got;
        // R1: reset state
        do_reset();
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 erase_req", erase_req, 0);
        chk("R1 write_req", write_req, 0);
        chk("R1 session_err", session_err, 0);

        // R3 R4 R5: vector table of index and length cases
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            open_session(VECS[v].idx, VECS[v].len, acc);
            chk($sformatf("R4 R3 vec%0d accept", v), acc, VECS[v].acc);
            chk($sformatf("R4 vec%0d err", v), session_err, !VECS[v].acc);
        end

        // R7 R8 R5: two-page transfer of 300 bytes, MSB-first length
        do_reset();
        open_session(8'h1B, 32'd300, acc);
        chk("R5 length 300 accepted", acc, 1);
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 256; k++) send(pat(p, k));
            for (int w = 0; w < 5 && !write_req; w++) @(negedge clk);
            chk("R7 write_req", write_req, 1);
            chk("R7 write_page", write_page, p);
            foreach (VECS[a]) begin
                wbuf_raddr = 8'(a * 28);
                #1 chk("R7 buffer byte", wbuf_rdata, pat(p, a * 28));
            end
            wbuf_raddr = 8'd255;
            #1 chk("R7 buffer last", wbuf_rdata, pat(p, 255));
            repeat (4) @(negedge clk);
            chk("R12 write_req held", write_req, 1);
            chk("R12 page stable", write_page, p);
            write_done = 1;
            @(negedge clk) write_done = 0;
            get_ack(3, got);
            chk("R9 page ack held", got, 1);
        end
        send(8'h10);
        get_ack(0, got);
        chk("R8 session ended, new start acked", got, 1);
        chk("R8 no error", session_err, 0);

        // R11: wrong command at start, then sticky
        do_reset();
        send(8'h12);
        chk("R11 bad command err", session_err, 1);
        chk("R11 no ack", tx_valid, 0);
        send(8'h10);
        repeat (3) @(negedge clk);
        chk("R11 ignored in error", tx_valid, 0);

        // R11: index above range
        do_reset();
        send(8'h10); get_ack(0, got);
        send(8'h11); send(8'h1C);
        chk("R11 index 1Ch err", session_err, 1);
        chk("R11 no erase", erase_req, 0);

        // R10: overrun after start
        do_reset();
        send(8'h10); get_ack(0, got);
        @(negedge clk) rx_overrun = 1;
        @(negedge clk) rx_overrun = 0;
        chk("R10 overrun err", session_err, 1);
        repeat (3) @(negedge clk);
        chk("R10 err sticky", session_err, 1);

        // R10: framing error during data
        do_reset();
        open_session(8'h14, 32'd512, acc);
        send(8'hAA);
        @(negedge clk) rx_frame_err = 1;
        @(negedge clk) rx_frame_err = 0;
        chk("R10 framing err", session_err, 1);
        do_reset();
        chk("R1 reset clears err", session_err, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule